// File: doc/BRIEF.md
# Pipelined Constant-Coefficient FIR Filter

This block is a fixed-response direct-form FIR filter. Every tap weight is a build-time parameter written as a canonical signed digit (CSD) vector. Each constant product is formed only from shifted copies of the sample, added or subtracted according to the nonzero digits, so no general multiplier appears in the logic. The sum over all taps is kept at full precision.

The taps are split into consecutive groups. One register sits after the partial sum of each group, and the partial sums run from the oldest group towards the newest. The registers that this pipelining adds are taken out of the sample delay line, so the total register count does not grow. The longest path between registers is one constant product plus one adder per tap of a group. With the default 15 taps in groups of 3, that is one product and three adders, where an unpipelined chain would need fourteen adders.

All state advances only on cycles with an input strobe. A stream with gaps therefore yields the same outputs as the same stream sent back to back. The result for the newest accepted sample is presented one clock later, together with a valid flag.

Top module: `csd_retimed_fir`

## Requirements
- R1: For each accepted sample s, the output equals the sum over k of c_k * x[s-k], bit-exact, where x is the sequence of accepted samples. Samples from before the last reset count as zero.
- R2: Coefficient k is element k of `COEFS`. Its digit i occupies bits [2i+1:2i], where 2'b01 means +1, 2'b11 means -1 and 2'b00 means 0, and its integer value is the sum of d_i * 2^i. The default set, in tap order from 0 to 14, is 2, -5, 0, 12, -18, 0, 40, 64, 40, 0, -18, 12, 0, -5, 2.
- R3: `out_data` is IN_W+NDIG+ceil(log2(NTAPS)) bits wide (20 by default). It never wraps, including when every input sits at its most negative or most positive value with the sign of the matching coefficient.
- R4: The result and valid flag for a sample accepted at a rising edge are visible right after that edge: `LATENCY` = 1 clock.
- R5: After reset, the first NGRP-1 accepted samples (4 by default) produce no `out_valid`. From then on, each accepted sample produces exactly one `out_valid` pulse.
- R6: In a cycle with `in_valid` low, no state advances: at the next edge `out_valid` falls low and `out_data` keeps its value. Gaps between samples do not change any result.
- R7: A synchronous reset clears the delay line, the partial sums and the warm-up count. Right after reset `out_valid` is 0 and `out_data` is 0, and no pre-reset sample leaks into later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the pipeline advances only when high |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | High for one clock with each full-precision result |
| out_data | output | OUT_W | Signed filter result, full precision |

## Verification
Every result is due exactly one clock after the edge that accepts its sample. The bench drives each sample on a falling edge and reads `out_valid` and `out_data` on the next falling edge, after the accepting rising edge. In idle cycles it checks on the same cadence that `out_valid` has dropped and `out_data` is unchanged. The reference is a shift-register convolution that advances only on accepted samples and clears on reset. It therefore predicts the warm-up window, the impulse taps, the step settling and the results across random gaps with no cycle counting beyond that single clock.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // CSD digit codes (two bits per digit)
    typedef enum logic [1:0] {
        CSD_ZERO = 2'b00,
        CSD_POS  = 2'b01,
        CSD_NEG  = 2'b11
    } csd_dig_e;

    // full-precision result width: sample + coefficient digits + guard bits
    function automatic int acc_width(input int in_w, input int ndig, input int ntaps);
        return in_w + ndig + $clog2(ntaps);
    endfunction

endpackage

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
    parameter int                IN_W = 8,
    parameter int                NDIG = 8,
    parameter logic [2*NDIG-1:0] COEF = '0,
    localparam int               PW   = IN_W + NDIG
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] x,
    output logic signed [PW-1:0]   prod
);

    function automatic longint csd_decode(input logic [2*NDIG-1:0] c);
        longint v;
        v = 0;
        for (int i = 0; i < NDIG; i++) begin
            if (c[2*i +: 2] == fir_pkg::CSD_POS) v = v + (longint'(1) <<< i);
            else if (c[2*i +: 2] == fir_pkg::CSD_NEG) v = v - (longint'(1) <<< i);
        end
        return v;
    endfunction

    localparam longint             CVAL_I = csd_decode(COEF);
    localparam logic signed [PW-1:0] CVAL = CVAL_I[PW-1:0];

    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] term [NDIG];

    assign xs = {{NDIG{x[IN_W-1]}}, x};

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        localparam logic [1:0] DG = COEF[2*i +: 2];
        if (DG == fir_pkg::CSD_POS) begin : g_pos
            assign term[i] = xs <<< i;
        end else if (DG == fir_pkg::CSD_NEG) begin : g_neg
            assign term[i] = -(xs <<< i);
        end else begin : g_zero
            assign term[i] = '0;
        end
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < NDIG; i++) begin
            prod = prod + term[i];
        end
    end

    // shift-and-add result matches a true multiply by the decoded constant (R2)
    p_csd_product_r2: assert property (@(posedge clk) disable iff (rst)
        prod == xs * CVAL);

endmodule

// File: rtl/fir_group.sv
module fir_group #(
    parameter int                        IN_W  = 8,
    parameter int                        NDIG  = 8,
    parameter int                        NT    = 3,
    parameter int                        OUT_W = 20,
    parameter logic [NT-1:0][2*NDIG-1:0] COEFS = '0,
    localparam int                       PW    = IN_W + NDIG
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NT-1:0][IN_W-1:0]      taps,
    input  logic signed [OUT_W-1:0]      acc_in,
    output logic signed [OUT_W-1:0]      acc_out
);

    logic signed [PW-1:0] prod [NT];

    for (genvar i = 0; i < NT; i++) begin : g_tap
        csd_const_mult #(
            .IN_W (IN_W),
            .NDIG (NDIG),
            .COEF (COEFS[i])
        ) i_mult (
            .clk  (clk),
            .rst  (rst),
            .x    ($signed(taps[i])),
            .prod (prod[i])
        );
    end

    // one adder per tap: the incoming partial sum plus the NT products
    always_comb begin
        acc_out = acc_in;
        for (int i = 0; i < NT; i++) begin
            acc_out = acc_out + OUT_W'(prod[i]);
        end
    end

endmodule

// File: rtl/csd_retimed_fir.sv
module csd_retimed_fir #(
    parameter int                           NTAPS = 15,
    parameter int                           GRP   = 3,
    parameter int                           IN_W  = 8,
    parameter int                           NDIG  = 8,
    parameter logic [NTAPS-1:0][2*NDIG-1:0] COEFS = {
        16'h0004, 16'h0033, 16'h0000, 16'h0130, 16'h030C,
        16'h0000, 16'h0440, 16'h1000, 16'h0440, 16'h0000,
        16'h030C, 16'h0130, 16'h0000, 16'h0033, 16'h0004},
    localparam int                          OUT_W = fir_pkg::acc_width(IN_W, NDIG, NTAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    localparam int NGRP    = (NTAPS + GRP - 1) / GRP;
    localparam int DL      = NTAPS - NGRP;       // delay registers left after the cutset move
    localparam int DLS     = (DL > 0) ? DL : 1;
    localparam int FW      = $clog2(NGRP) + 1;
    localparam int LATENCY = 1;                   // clocks from accepting edge to result

    typedef struct packed {
        logic [DLS-1:0][IN_W-1:0]   dly;   // dly[m] holds the sample m+1 strobes old
        logic [NGRP-1:0][OUT_W-1:0] acc;   // registered partial sum after each group
        logic [FW-1:0]              fill;
        logic                       vld;
    } state_t;

    state_t s_d, s_q;

    logic [NTAPS-1:0][IN_W-1:0] tapv;
    logic signed [OUT_W-1:0]    ain  [NGRP];
    logic signed [OUT_W-1:0]    gsum [NGRP];

    // tap k of group j reads the sample k-j strobes old; index 0 is the live input
    for (genvar k = 0; k < NTAPS; k++) begin : g_tapsel
        localparam int J = k / GRP;
        localparam int D = k - J;
        if (D == 0) begin : g_live
            assign tapv[k] = in_data;
        end else begin : g_dly
            assign tapv[k] = s_q.dly[D-1];
        end
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        localparam int NT = ((NTAPS - j*GRP) < GRP) ? (NTAPS - j*GRP) : GRP;
        if (j == NGRP-1) begin : g_head
            assign ain[j] = '0;
        end else begin : g_link
            assign ain[j] = $signed(s_q.acc[j+1]);
        end
        fir_group #(
            .IN_W  (IN_W),
            .NDIG  (NDIG),
            .NT    (NT),
            .OUT_W (OUT_W),
            .COEFS (COEFS[j*GRP +: NT])
        ) i_group (
            .clk     (clk),
            .rst     (rst),
            .taps    (tapv[j*GRP +: NT]),
            .acc_in  (ain[j]),
            .acc_out (gsum[j])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (in_valid) begin
            if (DL > 0) begin
                for (int m = DLS-1; m > 0; m--) begin
                    s_d.dly[m] = s_q.dly[m-1];
                end
                s_d.dly[0] = in_data;
            end
            for (int j = 0; j < NGRP; j++) begin
                s_d.acc[j] = gsum[j];
            end
            s_d.vld = (s_q.fill == FW'(NGRP-1));
            if (s_q.fill != FW'(NGRP-1)) begin
                s_d.fill = s_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_data  = $signed(s_q.acc[0]);

    // independent strobe counter for the checks below
    logic [FW:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (in_valid && seen_q != (FW+1)'(NGRP)) seen_q <= seen_q + 1'b1;
    end

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_warmup_window_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |-> (out_valid == (seen_q == (FW+1)'(NGRP))));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && !out_valid));

endmodule

// File: tb/test_csd_retimed_fir.sv
module test_csd_retimed_fir;

    localparam int IN_W  = 8;
    localparam int OUT_W = 20;
    localparam int NT    = 15;
    localparam int WARM  = 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // R2: default coefficients in tap order
    int cref [NT] = '{2, -5, 0, 12, -18, 0, 40, 64, 40, 0, -18, 12, 0, -5, 2};
    int hist [NT];
    int nsamp;
    int last_out;

    csd_retimed_fir i_csd_retimed_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4ns clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NT; k++) hist[k] = 0;
        nsamp    = 0;
        last_out = 0;
    endtask

    // R7: reset state
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check(out_valid == 1'b0, "R7 valid after reset", int'(out_valid), 0);
        check(out_data == '0, "R7 data after reset", int'(out_data), 0);
    endtask

    // push one sample; result is due one clock later (R4)
    task automatic push(input int v, input string req);
        int exp;
        bit expv;
        in_valid = 1'b1;
        in_data  = IN_W'(v);
        for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
        exp = 0;
        for (int k = 0; k < NT; k++) exp += cref[k] * hist[k];
        expv = (nsamp >= WARM);
        nsamp++;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == expv, {req, " R5 valid"}, int'(out_valid), int'(expv));
        if (expv) check(int'(out_data) == exp, {req, " R4 data"}, int'(out_data), exp);
        last_out = int'(out_data);
    endtask

    // R6: idle cycles hold output and drop valid
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6 idle valid", int'(out_valid), 0);
            check(int'(out_data) == last_out, "R6 idle hold", int'(out_data), last_out);
        end
    endtask

    task automatic t_impulse();
        for (int i = 0; i < WARM; i++) push(0, "R5 warmup");
        push(100, "R1 impulse");
        for (int i = 0; i < NT + 2; i++) push(0, "R1 impulse");
    endtask

    task automatic t_step();
        for (int i = 0; i < 20; i++) push(37, "R1 step");
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            push(int'($signed(IN_W'($urandom))), "R6 random gaps");
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end
    endtask

    // R3: inputs at the rails with the coefficient sign
    task automatic t_extreme();
        for (int j = 0; j < NT; j++)
            push((cref[NT-1-j] < 0) ? 127 : -128, "R3 rail low");
        for (int j = 0; j < NT; j++)
            push((cref[NT-1-j] < 0) ? -128 : 127, "R3 rail high");
    endtask

    initial begin
        model_clear();
        t_reset();
        t_impulse();
        idle(2);
        t_step();
        t_random();
        t_reset();      // R7: history before reset must not leak
        t_impulse();
        t_reset();
        t_extreme();
        idle(1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule